// File: doc/BRIEF.md
# 32-Pin GPIO Port with Per-Pin Interrupt Detection

This block is a general-purpose I/O port of 32 pins that sits on a simple single-cycle register bus with a 32-bit data path. Software writes an output value and a direction per pin. It reads back the synchronised pad levels. For each pin it picks how an input change raises an interrupt: low level, high level, rising edge, falling edge, or both edges.

Each pad input passes through a two-flop synchroniser. A per-pin detector compares the current synchronised sample with the one before it, under the pin's trigger setting. A hit latches a status bit, which software clears by writing 1. A mask gates the latched bits onto two interrupt lines: one for the lower sixteen pins and one for the upper sixteen.

The bus is addressed by a 3-bit word index. The byte offset is the index times four. Index 0 is output data, 1 is direction, 2 is pad levels (read only), 3 is the trigger fields for pins 0-15, 4 is the trigger fields for pins 16-31, 5 is the mask, 6 is the latched status, and 7 is the both-edges override. A read returns the selected word combinationally in the same cycle. A write takes effect at the next clock edge.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is high, every register (data, direction, triggers, mask, status, both-edges) and the synchroniser clear to zero. So after reset pad_oe is 0, both interrupt lines are low and every word reads 0.
- R2: pad_out equals the data word (index 0) and pad_oe equals the direction word (index 1); a 1 in the direction word drives the pin. Reading index 0 returns the last written data, whatever the pads carry.
- R3: Reading index 2 returns the pad inputs after two flops: a pad value present at clock edge k reads back after edge k+1.
- R4: Pin p takes a 2-bit trigger field from index 3 (p<16) or index 4 (p>=16) at bits [2*(p mod 16)+1 : 2*(p mod 16)]. The encoding is 0 low level, 1 high level, 2 rising edge, 3 falling edge. An edge is a difference between the current and previous synchronised samples.
- R5: When bit p of the both-edges word (index 7) is 1, pin p detects every change of its synchronised sample in either direction, and its trigger field has no effect.
- R6: Writing index 6 clears each status bit written as 1 and leaves bits written as 0 unchanged. Status bits never clear otherwise.
- R7: irq_lo is high exactly when some pin 0-15 has both its status bit and its mask bit (index 5) set. irq_hi does the same for pins 16-31.
- R8: A detection in the same cycle as a clear of that bit leaves the bit set. A level trigger re-detects on every cycle the level holds, so clearing it while the level persists leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_word | input | 3 | Register word index |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq_lo | output | 1 | Interrupt for pins 0-15 |
| irq_hi | output | 1 | Interrupt for pins 16-31 |

## Verification
The bench aims at the trigger field split across the two words: a design that indexed the upper-half fields from the wrong word, or at the wrong bit, would flag the falling edge on pin 20 as absent or flag the rising edge as a hit. It drives a both-edges pin through a falling edge while its field says rising; a design that let the field win would miss that interrupt. It clears a held high-level pin and expects the bit to survive, and it writes zeros to the status word. A design that gave the clear priority, or cleared on any status write, would drop a bit that should stay set. A reference model runs beside the design every cycle. It catches a synchroniser one flop short or long, because the pad-level reads and the edge timing then come a cycle early or late.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int GPIO_PINS = 32;
    localparam int GPIO_HALF = GPIO_PINS / 2;
    localparam int TRIG_W    = 2;
    localparam int SEL_W     = 3;
    localparam int SYNC_LEN  = 2;

    typedef logic [GPIO_PINS-1:0] pinvec_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA    = 3'd0,
        SEL_DIR     = 3'd1,
        SEL_PADS    = 3'd2,
        SEL_TRIG_LO = 3'd3,
        SEL_TRIG_HI = 3'd4,
        SEL_MASK    = 3'd5,
        SEL_STAT    = 3'd6,
        SEL_BOTH    = 3'd7
    } reg_sel_t;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_LEVEL_LO = 2'd0,
        TRIG_LEVEL_HI = 2'd1,
        TRIG_RISE     = 2'd2,
        TRIG_FALL     = 2'd3
    } trig_t;

    typedef struct packed {
        pinvec_t data;
        pinvec_t dir;
        pinvec_t trig_lo;
        pinvec_t trig_hi;
        pinvec_t mask;
        pinvec_t both;
    } ctl_regs_t;

    // Trigger field of one pin, taken from the word that holds its half.
    function automatic trig_t field_of(input pinvec_t lo, input pinvec_t hi, input int pin);
        int base;
        base = TRIG_W * (pin % GPIO_HALF);
        if (pin < GPIO_HALF)
            return trig_t'(lo[base +: TRIG_W]);
        else
            return trig_t'(hi[base +: TRIG_W]);
    endfunction

    // Whether a bus write lands on a given word.
    function automatic logic hits(input logic wen, input reg_sel_t sel, input reg_sel_t target);
        return wen && (sel == target);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_irq_pkg::*;
#(
    parameter int W      = GPIO_PINS,
    parameter int STAGES = SYNC_LEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] last
);
    localparam int CHAIN = STAGES + 1;

    logic [W-1:0] stg [CHAIN];

    genvar i;
    generate
        for (i = 0; i < CHAIN; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= din;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign cur  = stg[STAGES-1];
    assign last = stg[STAGES];

endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
    import gpio_irq_pkg::*;
(
    input  trig_t mode,
    input  logic  both,
    input  logic  cur,
    input  logic  last,
    output logic  hit
);
    always_comb begin
        if (both) begin
            hit = cur ^ last;
        end else begin
            unique case (mode)
                TRIG_LEVEL_LO: hit = ~cur;
                TRIG_LEVEL_HI: hit = cur;
                TRIG_RISE:     hit = cur & ~last;
                TRIG_FALL:     hit = ~cur & last;
                default:       hit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wen,
    input  reg_sel_t  sel,
    input  pinvec_t   wdata,
    input  pinvec_t   pads,
    input  pinvec_t   det,
    output ctl_regs_t ctl,
    output pinvec_t   stat,
    output pinvec_t   rdata
);
    pinvec_t clr;
    pinvec_t stat_nx;

    always_comb begin
        clr     = hits(wen, sel, SEL_STAT) ? wdata : '0;
        stat_nx = (stat & ~clr) | det;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl  <= '0;
            stat <= '0;
        end else begin
            stat <= stat_nx;
            if (hits(wen, sel, SEL_DATA))    ctl.data    <= wdata;
            if (hits(wen, sel, SEL_DIR))     ctl.dir     <= wdata;
            if (hits(wen, sel, SEL_TRIG_LO)) ctl.trig_lo <= wdata;
            if (hits(wen, sel, SEL_TRIG_HI)) ctl.trig_hi <= wdata;
            if (hits(wen, sel, SEL_MASK))    ctl.mask    <= wdata;
            if (hits(wen, sel, SEL_BOTH))    ctl.both    <= wdata;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_DATA:    rdata = ctl.data;
            SEL_DIR:     rdata = ctl.dir;
            SEL_PADS:    rdata = pads;
            SEL_TRIG_LO: rdata = ctl.trig_lo;
            SEL_TRIG_HI: rdata = ctl.trig_hi;
            SEL_MASK:    rdata = ctl.mask;
            SEL_STAT:    rdata = stat;
            SEL_BOTH:    rdata = ctl.both;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SEL_W-1:0]     bus_word,
    input  logic                 bus_wen,
    input  logic [GPIO_PINS-1:0] bus_wdata,
    output logic [GPIO_PINS-1:0] bus_rdata,
    input  logic [GPIO_PINS-1:0] pad_in,
    output logic [GPIO_PINS-1:0] pad_out,
    output logic [GPIO_PINS-1:0] pad_oe,
    output logic                 irq_lo,
    output logic                 irq_hi
);
    reg_sel_t  sel;
    ctl_regs_t ctl;
    pinvec_t   smp_cur;
    pinvec_t   smp_last;
    pinvec_t   det;
    pinvec_t   stat;
    pinvec_t   pend;

    assign sel = reg_sel_t'(bus_word);

    gpio_sync #(.W(GPIO_PINS), .STAGES(SYNC_LEN)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pad_in),
        .cur  (smp_cur),
        .last (smp_last)
    );

    genvar p;
    generate
        for (p = 0; p < GPIO_PINS; p++) begin : g_pin
            gpio_pin_detect u_det (
                .mode (field_of(ctl.trig_lo, ctl.trig_hi, p)),
                .both (ctl.both[p]),
                .cur  (smp_cur[p]),
                .last (smp_last[p]),
                .hit  (det[p])
            );
        end
    endgenerate

    gpio_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wen   (bus_wen),
        .sel   (sel),
        .wdata (bus_wdata),
        .pads  (smp_cur),
        .det   (det),
        .ctl   (ctl),
        .stat  (stat),
        .rdata (bus_rdata)
    );

    assign pend    = stat & ctl.mask;
    assign irq_lo  = |pend[GPIO_HALF-1:0];
    assign irq_hi  = |pend[GPIO_PINS-1:GPIO_HALF];
    assign pad_out = ctl.data;
    assign pad_oe  = ctl.dir;

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     wen,
    input reg_sel_t sel,
    input pinvec_t  wdata,
    input pinvec_t  pad_oe,
    input pinvec_t  stat,
    input pinvec_t  mask,
    input pinvec_t  both,
    input pinvec_t  det,
    input pinvec_t  cur,
    input pinvec_t  last,
    input logic     irq_lo,
    input logic     irq_hi
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (pad_oe == '0 && stat == '0 && !irq_lo && !irq_hi));

    // R2
    dir_drives_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (wen && sel == SEL_DIR) |=> (pad_oe == $past(wdata)));

    // R5
    both_no_false_hit_chk: assert property (@(posedge clk) disable iff (rst)
        ((det & both & ~(cur ^ last)) == '0));

    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (wen && sel == SEL_STAT) |=> ((stat & $past(wdata & ~det)) == '0));

    // R6
    no_spurious_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !(wen && sel == SEL_STAT) |=> (($past(stat) & ~stat) == '0));

    // R7
    irq_lo_needs_mask_chk: assert property (@(posedge clk) disable iff (rst)
        irq_lo |-> (mask[GPIO_HALF-1:0] != '0));

    // R7
    irq_hi_needs_mask_chk: assert property (@(posedge clk) disable iff (rst)
        irq_hi |-> (mask[GPIO_PINS-1:GPIO_HALF] != '0));

    // R8
    detect_latches_chk: assert property (@(posedge clk) disable iff (rst)
        (det != '0) |=> ((stat & $past(det)) == $past(det)));

endmodule

bind gpio_irq_port gpio_irq_port_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .wen    (bus_wen),
    .sel    (sel),
    .wdata  (bus_wdata),
    .pad_oe (pad_oe),
    .stat   (stat),
    .mask   (ctl.mask),
    .both   (ctl.both),
    .det    (det),
    .cur    (smp_cur),
    .last   (smp_last),
    .irq_lo (irq_lo),
    .irq_hi (irq_hi)
);

// File: tb/gpio_irq_port_test.sv
`timescale 1ns/1ps
module gpio_irq_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_word = 3'd0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq_lo, irq_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    gpio_irq_port uut (
        .clk(clk), .rst(rst), .bus_word(bus_word), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // Behavioural reference model
    bit [31:0] m_data, m_dir, m_tlo, m_thi, m_mask, m_both, m_stat;
    bit [31:0] m_s1, m_cur, m_last;

    function automatic string word_tag(input int w);
        case (w)
            0, 1:    return "R2";
            2:       return "R3";
            3, 4:    return "R4";
            5:       return "R7";
            6:       return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic cmp(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %h exp %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit [31:0] det, clr, exp_rd;
        int mode;
        if (rst) begin
            m_data = 0; m_dir = 0; m_tlo = 0; m_thi = 0; m_mask = 0; m_both = 0;
            m_stat = 0; m_s1 = 0; m_cur = 0; m_last = 0;
        end else begin
            det = 0;
            for (int p = 0; p < 32; p++) begin
                mode = (p < 16) ? int'((m_tlo >> (2*p)) & 3) : int'((m_thi >> (2*(p-16))) & 3);
                if (m_both[p]) det[p] = (m_cur[p] != m_last[p]);
                else case (mode)
                    0: det[p] = !m_cur[p];
                    1: det[p] = m_cur[p];
                    2: det[p] = m_cur[p] && !m_last[p];
                    default: det[p] = !m_cur[p] && m_last[p];
                endcase
            end
            clr = (bus_wen && bus_word == 3'd6) ? bus_wdata : 32'h0;
            m_stat = (m_stat & ~clr) | det;
            if (bus_wen) case (bus_word)
                3'd0: m_data = bus_wdata;
                3'd1: m_dir  = bus_wdata;
                3'd3: m_tlo  = bus_wdata;
                3'd4: m_thi  = bus_wdata;
                3'd5: m_mask = bus_wdata;
                3'd7: m_both = bus_wdata;
                default: ;
            endcase
            m_last = m_cur; m_cur = m_s1; m_s1 = pad_in;
        end
        #1;
        case (bus_word)
            3'd0: exp_rd = m_data;  3'd1: exp_rd = m_dir;  3'd2: exp_rd = m_cur;
            3'd3: exp_rd = m_tlo;   3'd4: exp_rd = m_thi;  3'd5: exp_rd = m_mask;
            3'd6: exp_rd = m_stat;  default: exp_rd = m_both;
        endcase
        if (!done) begin
            cmp(rst ? "R1" : word_tag(bus_word), "rdata", bus_rdata, exp_rd);
            cmp(rst ? "R1" : "R2", "pad_out", pad_out, m_data);
            cmp(rst ? "R1" : "R2", "pad_oe", pad_oe, m_dir);
            cmp(rst ? "R1" : "R7", "irq_lo", {31'b0, irq_lo}, {31'b0, |(m_stat[15:0] & m_mask[15:0])});
            cmp(rst ? "R1" : "R7", "irq_hi", {31'b0, irq_hi}, {31'b0, |(m_stat[31:16] & m_mask[31:16])});
        end
    end

    task automatic wr(input int w, input logic [31:0] d);
        @(negedge clk);
        bus_word = w[2:0]; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd_chk(input int w, input logic [31:0] msk, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_word = w[2:0];
        @(posedge clk); #1.5;
        cmp(tag, "directed read", bus_rdata & msk, exp & msk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rd_chk(0, 32'hFFFFFFFF, 32'h0, "R1");
        rd_chk(6, 32'hFFFFFFFF, 32'h0, "R1");
        @(negedge clk); rst = 1'b0;
        // R2: data and direction
        wr(0, 32'hA5A5_0F0F);
        wr(1, 32'hFFFF_0000);
        pad_in = 32'h1234_5678;
        cmp("R2", "pad_oe direct", pad_oe, 32'hFFFF_0000);
        cmp("R2", "pad_out direct", pad_out, 32'hA5A5_0F0F);
        rd_chk(0, 32'hFFFFFFFF, 32'hA5A5_0F0F, "R2");
        // R3: pad levels after synchroniser
        idle(3);
        rd_chk(2, 32'hFFFFFFFF, 32'h1234_5678, "R3");
        // R4: low half rising, high half falling
        wr(3, 32'hAAAA_AAAA);
        wr(4, 32'hFFFF_FFFF);
        pad_in = 32'h0;
        idle(4);
        wr(6, 32'hFFFF_FFFF);
        rd_chk(6, 32'hFFFFFFFF, 32'h0, "R6");
        pad_in = 32'h0000_0008;
        idle(4);
        rd_chk(6, 32'hFFFFFFFF, 32'h0000_0008, "R4");
        pad_in = 32'h0010_0008;
        idle(4);
        rd_chk(6, 32'hFFFFFFFF, 32'h0000_0008, "R4");
        pad_in = 32'h0000_0008;
        idle(4);
        rd_chk(6, 32'hFFFFFFFF, 32'h0010_0008, "R4");
        // R6: zero write keeps, one write clears
        wr(6, 32'h0);
        rd_chk(6, 32'hFFFFFFFF, 32'h0010_0008, "R6");
        wr(6, 32'h0000_0008);
        rd_chk(6, 32'hFFFFFFFF, 32'h0010_0000, "R6");
        // R7: mask gating and halves
        wr(5, 32'h0);
        cmp("R7", "irq_hi masked", {31'b0, irq_hi}, 32'h0);
        wr(5, 32'h0010_0000);
        cmp("R7", "irq_hi on", {31'b0, irq_hi}, 32'h1);
        cmp("R7", "irq_lo off", {31'b0, irq_lo}, 32'h0);
        wr(5, 32'h0000_FFFF);
        cmp("R7", "irq_lo none pending", {31'b0, irq_lo}, 32'h0);
        // R5: both edges on pin 0, field says rising
        wr(6, 32'hFFFF_FFFF);
        wr(7, 32'h0000_0001);
        pad_in = 32'h0000_0009;
        idle(4);
        rd_chk(6, 32'h0000_0001, 32'h1, "R5");
        cmp("R7", "irq_lo pending", {31'b0, irq_lo}, 32'h1);
        wr(6, 32'h0000_0001);
        rd_chk(6, 32'h0000_0001, 32'h0, "R5");
        pad_in = 32'h0000_0008;
        idle(4);
        rd_chk(6, 32'h0000_0001, 32'h1, "R5");
        // R8: held high level survives a clear
        wr(7, 32'h0);
        wr(3, 32'hAAAA_A6AA);
        pad_in = 32'h0000_0028;
        idle(4);
        wr(6, 32'h0000_0020);
        rd_chk(6, 32'h0000_0020, 32'h20, "R8");
        pad_in = 32'h0000_0008;
        idle(4);
        wr(6, 32'h0000_0020);
        rd_chk(6, 32'h0000_0020, 32'h0, "R8");
        idle(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired got running exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule